// File: doc/BRIEF.md
# Multiframe Synchronizer with Q-Channel Insertion

This block follows the 20-frame multiframe carried on a basic-rate four-wire subscriber interface. Frame recovery logic upstream of it presents one strobe per received frame together with three recovered bits: the auxiliary framing bit (FA/N), the multiframe marker bit (M) and the S-channel bit. The block checks these bits against the expected multiframe pattern and decides whether multiframe alignment is held. For every frame it also provides the FA bit of the next frame sent back towards the network.

While alignment is held, the FA slot of every fifth transmitted frame carries one bit of a 4-bit Q-channel word, and the FA slot of every other frame carries zero. While alignment is not held, each received FA bit is sent straight back in the next transmitted frame. The four S-channel bits of each aligned multiframe are assembled into a word. A sticky interrupt then fires either at every multiframe boundary or only when that word differs from the one before it. Software clears the interrupt with a write-one-to-clear pulse. The S word then stays stable for the 19 frames that follow, which gives software time to read it.

Top module: `mfs_sync_q_top`

## Requirements
- R1: Frame index 0 has M=1, and every other frame has M=0. FA is 1 in frames 0, 5, 10 and 15 and 0 elsewhere. After two consecutive complete multiframes that match this pattern, `msyn` rises in the cycle after the strobe of frame 19 of the second multiframe. After reset `msyn` is 0.
- R2: While aligned, a single multiframe with a pattern error leaves `msyn` at 1, provided a clean multiframe follows it.
- R3: While aligned, pattern errors in two consecutive multiframes clear `msyn` after the strobe of the last frame of the second one.
- R4: `tx_fa` is updated on each frame strobe and gives the FA bit of the next transmitted frame. While aligned, frames 0, 5, 10 and 15 carry Q bits 3, 2, 1 and 0 in that order, and all other frames carry 0.
- R5: `q_hold` is sampled only at the multiframe boundary, on the strobe of frame 19. A change to it during a multiframe does not affect the Q bits sent in that multiframe.
- R6: While not aligned, `tx_fa` after a frame strobe equals the `rx_fa` of that frame.
- R7: With `mf_en` at 0, `msyn` is 0 from the next cycle onward and the block echoes FA as in R6.
- R8: While not aligned, an `rx_m` of 1 in a frame whose expected index is not 0 realigns the frame counter so that this frame is index 0. Alignment then follows after two clean multiframes counted from that frame.
- R9: With `irq_mode` at 0, `irq` is set at each multiframe boundary at which the block is aligned.
- R10: `irq` stays set until `irq_clr` is pulsed, and is 0 in the cycle after a pulse of `irq_clr` in which no event occurs. After reset `irq` is 0.
- R11: With `irq_mode` at 1, `irq` is set at an aligned boundary only if the new S word differs from the previous one.
- R12: The S bits received in frames 0, 5, 10 and 15 form `s_nibble` bits 3, 2, 1 and 0. `s_nibble` changes only at an aligned multiframe boundary and is stable between boundaries. After reset it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_stb | input | 1 | One-cycle pulse per received frame |
| rx_fa | input | 1 | Received FA/N bit of this frame |
| rx_m | input | 1 | Received M bit of this frame |
| rx_s | input | 1 | Received S-channel bit of this frame |
| mf_en | input | 1 | Multiframe operation enable |
| q_hold | input | 4 | Q-channel word to send |
| irq_mode | input | 1 | 0: interrupt every boundary, 1: only on S change |
| irq_clr | input | 1 | Write-one-to-clear pulse for the interrupt |
| tx_fa | output | 1 | FA bit for the next transmitted frame |
| msyn | output | 1 | Multiframe alignment status |
| s_nibble | output | 4 | Last aligned S-channel word |
| irq | output | 1 | Sticky multiframe interrupt |

## Verification
The hardest states to reach are the realignment hunt from a frame phase that is off by several frames, and the difference between one errored multiframe and two consecutive ones after lock. A multiframe task takes a corruption flag and builds every frame from the pattern. The bench pushes the counter off phase by sending unmarked junk frames before a clean marker. It then alternates errored and clean multiframes, so that only a run of two errors ends alignment.

// File: rtl/mfs_pkg.sv
package mfs_pkg;
  typedef enum logic {
    IRQ_EVERY_MF  = 1'b0,
    IRQ_ON_CHANGE = 1'b1
  } irq_sel_e;
endpackage

// File: rtl/mfs_frame_tracker.sv
module mfs_frame_tracker #(
  parameter int MF_LEN   = 20,
  parameter int Q_STRIDE = 5,
  parameter int GAIN_MF  = 2,
  parameter int LOSS_MF  = 2,
  localparam int POS_W   = $clog2(MF_LEN)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_stb,
  input  logic             rx_fa,
  input  logic             rx_m,
  input  logic             mf_en,
  output logic [POS_W-1:0] idx,
  output logic [POS_W-1:0] nidx,
  output logic             mf_end,
  output logic             locked_q,
  output logic             locked_d
);
  localparam int GW = $clog2(GAIN_MF + 1);
  localparam int LW = $clog2(LOSS_MF + 1);
  localparam logic [POS_W-1:0] LAST = POS_W'(MF_LEN - 1);

  logic [POS_W-1:0] pos_q, pos_d;
  logic             err_q, err_d;
  logic [GW-1:0]    clean_q, clean_d;
  logic [LW-1:0]    bad_q, bad_d;
  logic             realign, exp_m, exp_fa, mism, err_mf, upd;

  always_comb begin
    realign = frame_stb && !locked_q && mf_en && rx_m && (pos_q != '0);
    idx     = realign ? '0 : pos_q;
    exp_m   = (idx == '0);
    exp_fa  = ((idx % POS_W'(Q_STRIDE)) == '0);
    mism    = (rx_m != exp_m) || (rx_fa != exp_fa);
    err_mf  = (err_q && !realign) || mism;
    mf_end  = frame_stb && (idx == LAST);
    nidx    = (idx == LAST) ? '0 : idx + POS_W'(1);
    upd     = frame_stb || !mf_en;

    pos_d    = pos_q;
    err_d    = err_q;
    clean_d  = clean_q;
    bad_d    = bad_q;
    locked_d = locked_q;

    if (frame_stb) begin
      pos_d = nidx;
      err_d = mf_end ? 1'b0 : err_mf;
      if (realign) clean_d = '0;
    end

    if (!mf_en) begin
      locked_d = 1'b0;
      clean_d  = '0;
      bad_d    = '0;
    end else if (mf_end) begin
      if (!locked_q) begin
        if (err_mf) begin
          clean_d = '0;
        end else if (clean_q == GW'(GAIN_MF - 1)) begin
          locked_d = 1'b1;
          clean_d  = '0;
          bad_d    = '0;
        end else begin
          clean_d = clean_q + GW'(1);
        end
      end else begin
        if (!err_mf) begin
          bad_d = '0;
        end else if (bad_q == LW'(LOSS_MF - 1)) begin
          locked_d = 1'b0;
          bad_d    = '0;
          clean_d  = '0;
        end else begin
          bad_d = bad_q + LW'(1);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q    <= '0;
      err_q    <= 1'b0;
      clean_q  <= '0;
      bad_q    <= '0;
      locked_q <= 1'b0;
    end else if (upd) begin
      pos_q    <= pos_d;
      err_q    <= err_d;
      clean_q  <= clean_d;
      bad_q    <= bad_d;
      locked_q <= locked_d;
    end
  end
endmodule

// File: rtl/mfs_q_insert.sv
module mfs_q_insert #(
  parameter int MF_LEN   = 20,
  parameter int Q_STRIDE = 5,
  localparam int NIB     = MF_LEN / Q_STRIDE,
  localparam int POS_W   = $clog2(MF_LEN)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_stb,
  input  logic [POS_W-1:0] nidx,
  input  logic             locked_d,
  input  logic             rx_fa,
  input  logic [NIB-1:0]   q_hold,
  output logic             tx_fa
);
  localparam int SW = (NIB > 1) ? $clog2(NIB) : 1;

  logic [NIB-1:0] q_reg, q_reg_d, q_src;
  logic [SW-1:0]  slot;
  logic           is_slot, q_bit, tx_d;

  always_comb begin
    slot    = SW'(nidx / POS_W'(Q_STRIDE));
    is_slot = ((nidx % POS_W'(Q_STRIDE)) == '0);
    q_src   = (nidx == '0) ? q_hold : q_reg;
    q_bit   = q_src[SW'(NIB - 1) - slot];
    q_reg_d = (nidx == '0) ? q_hold : q_reg;
    tx_d    = locked_d ? (is_slot & q_bit) : rx_fa;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_reg <= '0;
      tx_fa <= 1'b0;
    end else if (frame_stb) begin
      q_reg <= q_reg_d;
      tx_fa <= tx_d;
    end
  end
endmodule

// File: rtl/mfs_s_collect.sv
module mfs_s_collect
  import mfs_pkg::*;
#(
  parameter int MF_LEN   = 20,
  parameter int Q_STRIDE = 5,
  localparam int NIB     = MF_LEN / Q_STRIDE,
  localparam int POS_W   = $clog2(MF_LEN)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_stb,
  input  logic [POS_W-1:0] idx,
  input  logic             mf_end,
  input  logic             locked_d,
  input  logic             rx_s,
  input  logic             irq_mode,
  input  logic             irq_clr,
  output logic [NIB-1:0]   s_nibble,
  output logic             irq
);
  localparam int SW = (NIB > 1) ? $clog2(NIB) : 1;

  logic [NIB-1:0] s_work, s_work_d, s_d;
  logic [SW-1:0]  slot;
  logic           is_slot, upd_s, changed, fire, irq_d;

  always_comb begin
    slot     = SW'(idx / POS_W'(Q_STRIDE));
    is_slot  = ((idx % POS_W'(Q_STRIDE)) == '0);
    s_work_d = s_work;
    if (frame_stb && is_slot) s_work_d[SW'(NIB - 1) - slot] = rx_s;
    upd_s    = mf_end && locked_d;
    changed  = (s_work_d != s_nibble);
    s_d      = upd_s ? s_work_d : s_nibble;
    fire     = upd_s && ((irq_sel_e'(irq_mode) == IRQ_EVERY_MF) || changed);
    irq_d    = fire ? 1'b1 : (irq_clr ? 1'b0 : irq);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_work <= '0;
    end else if (frame_stb) begin
      s_work <= s_work_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_nibble <= '0;
    end else if (mf_end) begin
      s_nibble <= s_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq <= 1'b0;
    end else begin
      irq <= irq_d;
    end
  end
endmodule

// File: rtl/mfs_sync_q_top.sv
module mfs_sync_q_top #(
  parameter int MF_LEN   = 20,
  parameter int Q_STRIDE = 5,
  parameter int GAIN_MF  = 2,
  parameter int LOSS_MF  = 2,
  localparam int NIB     = MF_LEN / Q_STRIDE
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           frame_stb,
  input  logic           rx_fa,
  input  logic           rx_m,
  input  logic           rx_s,
  input  logic           mf_en,
  input  logic [NIB-1:0] q_hold,
  input  logic           irq_mode,
  input  logic           irq_clr,
  output logic           tx_fa,
  output logic           msyn,
  output logic [NIB-1:0] s_nibble,
  output logic           irq
);
  localparam int POS_W = $clog2(MF_LEN);

  logic [1:0]       rst_sync_q;
  logic             rst_int_n;
  logic [POS_W-1:0] idx, nidx;
  logic             mf_end, locked_q, locked_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  mfs_frame_tracker #(
    .MF_LEN(MF_LEN), .Q_STRIDE(Q_STRIDE), .GAIN_MF(GAIN_MF), .LOSS_MF(LOSS_MF)
  ) trk_i (
    .clk(clk), .rst_n(rst_int_n), .frame_stb(frame_stb), .rx_fa(rx_fa),
    .rx_m(rx_m), .mf_en(mf_en), .idx(idx), .nidx(nidx), .mf_end(mf_end),
    .locked_q(locked_q), .locked_d(locked_d)
  );

  mfs_q_insert #(.MF_LEN(MF_LEN), .Q_STRIDE(Q_STRIDE)) qins_i (
    .clk(clk), .rst_n(rst_int_n), .frame_stb(frame_stb), .nidx(nidx),
    .locked_d(locked_d), .rx_fa(rx_fa), .q_hold(q_hold), .tx_fa(tx_fa)
  );

  mfs_s_collect #(.MF_LEN(MF_LEN), .Q_STRIDE(Q_STRIDE)) scol_i (
    .clk(clk), .rst_n(rst_int_n), .frame_stb(frame_stb), .idx(idx),
    .mf_end(mf_end), .locked_d(locked_d), .rx_s(rx_s), .irq_mode(irq_mode),
    .irq_clr(irq_clr), .s_nibble(s_nibble), .irq(irq)
  );

  assign msyn = locked_q;
endmodule

// File: rtl/mfs_sync_q_chk.sv
module mfs_sync_q_chk #(
  parameter int NIB = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic           frame_stb,
  input logic           rx_fa,
  input logic           mf_en,
  input logic           irq_clr,
  input logic           tx_fa,
  input logic           msyn,
  input logic [NIB-1:0] s_nibble,
  input logic           irq
);
  p_msyn_rise_on_frame_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(msyn) |-> $past(frame_stb));

  p_msyn_fall_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(msyn) |-> ($past(frame_stb) || $past(!mf_en)));

  p_tx_hold_between_frames_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_stb |=> $stable(tx_fa));

  p_disable_drops_sync_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !mf_en |=> !msyn);

  p_disable_echo_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_stb && !mf_en) |=> (tx_fa == $past(rx_fa)));

  p_irq_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !irq_clr) |=> irq);

  p_irq_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_clr && !frame_stb) |=> !irq);

  p_s_stable_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_stb |=> $stable(s_nibble));
endmodule

bind mfs_sync_q_top mfs_sync_q_chk #(.NIB(NIB)) chk_i (
  .clk(clk), .rst_n(rst_n), .frame_stb(frame_stb), .rx_fa(rx_fa),
  .mf_en(mf_en), .irq_clr(irq_clr), .tx_fa(tx_fa), .msyn(msyn),
  .s_nibble(s_nibble), .irq(irq)
);

// File: tb/mfs_sync_q_top_tb_top.sv
module mfs_sync_q_top_tb_top;
  localparam time CLK_P = 20ns;

  logic       clk, rst_n, frame_stb, rx_fa, rx_m, rx_s, mf_en, irq_mode, irq_clr;
  logic [3:0] q_hold;
  logic       tx_fa, msyn, irq;
  logic [3:0] s_nibble;

  int   n_chk, n_fail;
  bit   done;
  logic tx_log [20];
  logic [3:0] s_mid;

  mfs_sync_q_top dut_i (
    .clk(clk), .rst_n(rst_n), .frame_stb(frame_stb), .rx_fa(rx_fa), .rx_m(rx_m),
    .rx_s(rx_s), .mf_en(mf_en), .q_hold(q_hold), .irq_mode(irq_mode),
    .irq_clr(irq_clr), .tx_fa(tx_fa), .msyn(msyn), .s_nibble(s_nibble), .irq(irq)
  );

  initial clk = 1'b0;
  always #(CLK_P / 2) clk = ~clk;

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic send_frame(logic m, logic fa, logic s);
    @(negedge clk);
    frame_stb = 1'b1; rx_m = m; rx_fa = fa; rx_s = s;
    @(negedge clk);
    frame_stb = 1'b0;
  endtask

  task automatic send_mf(bit bad, logic [3:0] s4);
    for (int i = 0; i < 20; i++) begin
      logic fa, s;
      fa = (i % 5 == 0);
      if (bad && i == 2) fa = 1'b1;
      s  = (i % 5 == 0) ? s4[3 - i / 5] : 1'b0;
      send_frame(i == 0, fa, s);
      tx_log[i] = tx_fa;
      if (i == 10) s_mid = s_nibble;
    end
  endtask

  task automatic pulse_clr();
    @(negedge clk); irq_clr = 1'b1;
    @(negedge clk); irq_clr = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 msyn after reset", msyn, 0);
    chk("R10 irq after reset", irq, 0);
    chk("R12 s_nibble after reset", s_nibble, 0);
  endtask

  task automatic t_gain();
    q_hold = 4'b1011;
    send_mf(0, 4'b0000);
    chk("R1 no sync after one clean multiframe", msyn, 0);
    chk("R6 echo of frame 0 FA while unaligned", tx_log[0], 1);
    send_mf(0, 4'b0000);
    chk("R1 sync after two clean multiframes", msyn, 1);
    chk("R4 Q bit 3 ahead of frame 0", tx_log[19], 1);
  endtask

  task automatic t_qins();
    int others;
    q_hold = 4'b0100;
    send_mf(0, 4'b0000);
    others = 0;
    for (int i = 0; i < 19; i++)
      if (i != 4 && i != 9 && i != 14 && tx_log[i] !== 1'b0) others++;
    chk("R4 Q bit 2 in frame 5", tx_log[4], 0);
    chk("R5 Q bit 1 from latched word", tx_log[9], 1);
    chk("R5 Q bit 0 from latched word", tx_log[14], 1);
    chk("R4 non-Q frames carry zero", others, 0);
    chk("R5 new word used from next boundary", tx_log[19], 0);
  endtask

  task automatic t_irq_every();
    pulse_clr();
    chk("R10 irq cleared by pulse", irq, 0);
    irq_mode = 1'b0;
    send_mf(0, 4'b1010);
    chk("R9 irq at aligned boundary", irq, 1);
    chk("R12 s_nibble assembled MSB first", s_nibble, 4'b1010);
    repeat (5) @(negedge clk);
    chk("R10 irq sticky without clear", irq, 1);
    pulse_clr();
    chk("R10 irq cleared again", irq, 0);
  endtask

  task automatic t_irq_change();
    irq_mode = 1'b1;
    send_mf(0, 4'b1010);
    chk("R11 no irq for unchanged S word", irq, 0);
    send_mf(0, 4'b0110);
    chk("R11 irq on changed S word", irq, 1);
    chk("R12 s_nibble stable mid multiframe", s_mid, 4'b1010);
    chk("R12 s_nibble updated at boundary", s_nibble, 4'b0110);
    pulse_clr();
  endtask

  task automatic t_loss();
    send_mf(1, 4'b0000);
    chk("R2 one errored multiframe keeps sync", msyn, 1);
    send_mf(0, 4'b0000);
    chk("R2 clean multiframe after error keeps sync", msyn, 1);
    send_mf(1, 4'b0000);
    chk("R2 first of two errored keeps sync", msyn, 1);
    send_mf(1, 4'b0000);
    chk("R3 two consecutive errored multiframes lose sync", msyn, 0);
  endtask

  task automatic t_echo();
    send_frame(0, 1, 0);
    chk("R6 echo FA=1", tx_fa, 1);
    send_frame(0, 0, 0);
    chk("R6 echo FA=0", tx_fa, 0);
    send_frame(0, 1, 0);
    chk("R6 echo FA=1 again", tx_fa, 1);
  endtask

  task automatic t_hunt();
    repeat (4) send_frame(0, 0, 0);
    send_mf(0, 4'b0000);
    chk("R8 no sync after first realigned multiframe", msyn, 0);
    send_mf(0, 4'b0000);
    chk("R8 sync after realign and two clean multiframes", msyn, 1);
  endtask

  task automatic t_disable();
    @(negedge clk); mf_en = 1'b0;
    @(negedge clk);
    chk("R7 msyn low when disabled", msyn, 0);
    send_frame(0, 1, 0);
    chk("R7 echo FA=1 when disabled", tx_fa, 1);
    send_frame(0, 0, 0);
    chk("R7 echo FA=0 when disabled", tx_fa, 0);
    mf_en = 1'b1;
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    n_chk = 0; n_fail = 0; done = 1'b0;
    rst_n = 1'b0; frame_stb = 1'b0; rx_fa = 1'b0; rx_m = 1'b0; rx_s = 1'b0;
    mf_en = 1'b1; q_hold = 4'b0000; irq_mode = 1'b0; irq_clr = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_gain();
    t_qins();
    t_irq_every();
    t_irq_change();
    t_loss();
    t_echo();
    t_hunt();
    t_disable();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule